// File: doc/BRIEF.md
# Address Range Cache Operation Sequencer

This block carries out one cache maintenance instruction over a span of memory addresses. It takes a start address, a candidate upper bound, the two register numbers of the instruction's combined source/destination operand, a three-bit operation code and the current privilege level. It walks the span one naturally aligned cache line at a time and sends each line to a cache controller on a request port. It waits for an acknowledge or a fault before it sends the next line. When it finishes it pulses `done_o` and returns a stop address for the destination register, with an exception code.

The stop address makes the instruction restartable. Software reloads the returned value as the new start address. It repeats the instruction while the stop address is below the upper bound, using an unsigned compare. The block may return early after a fixed number of lines, or at the next line boundary when an interrupt is pending. It always returns an address above the start address unless it raises an exception. Address permission and privilege rules depend on the operation type. Address translation, the permission lookup and the caches themselves sit outside the block.

Top module: `range_cmo_seq`

## Requirements
- R1: If `rd_idx_i` differs from `rs1_idx_i` when an instruction is accepted, the block sends no request, pulses `done_o` in the next cycle with `exc_o` = 1 (illegal) and returns the start address.
- R2: The effective upper bound is the unsigned maximum of start+1 and the candidate bound, so at least one line is processed even when the start address is at or above the candidate bound.
- R3: Each request address has its low log2(LINE_BYTES) bits at zero. The first request is the line that contains the start address, and each later one is the previous plus LINE_BYTES. Only one request is outstanding at a time, and `req_valid_o` and `req_addr_o` hold steady until `rsp_ack_i` or `rsp_fault_i` arrives.
- R4: No request is sent for a line whose base is at or above the effective upper bound.
- R5: When all lines are acknowledged, `exc_o` = 0 and the stop address is the boundary after the last line, which is at or above the upper bound. If that boundary is past the top of the address space, the stop address saturates to all ones.
- R6: A fault response gives `exc_o` = 4 (cache fault) and stops the walk. The stop address is the faulting line base, or the start address when the fault is on the first line.
- R7: Operation codes 0 (clean), 1 (flush) and 5 (hint) need `chk_rd_ok_i`, and code 2 (zero-allocate) needs `chk_wr_ok_i`. Both are sampled for `chk_addr_o` before each line is sent. A denial sends no request for that line and gives `exc_o` = 3, with the stop address formed as in R6.
- R8: Codes 3 (allocate without fill) and 4 (discard) need `priv_i` >= PRIV_MIN. Otherwise `exc_o` = 2 and the stop address is the start address, with no request. When the privilege is high enough, these codes do no address permission check.
- R9: After MAX_LINES acknowledged lines, the block stops with `exc_o` = 0 and returns the next line boundary, so a partly done span can be resumed.
- R10: If `irq_pend_i` is high when a line is acknowledged, the block stops after that line and returns the next line boundary with `exc_o` = 0.
- R11: When `skip_adv_i` is high for a hint (code 5), the block sends no request, checks no permission and returns `exc_o` = 0 with the line boundary that follows the start address.
- R12: `busy_o` is high from the cycle after an accepted start until `done_o`. `done_o` is a single-cycle pulse seen with `busy_o` low. A start while busy is ignored.
- R13: Codes 6 and 7 are illegal and are handled as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Accept a new instruction when idle |
| rd_idx_i | input | REG_W | Destination register number |
| rs1_idx_i | input | REG_W | First source register number |
| op_i | input | 3 | Operation code |
| priv_i | input | PRIV_W | Current privilege level |
| skip_adv_i | input | 1 | Skip an advisory operation |
| lwb_i | input | AW | Start address |
| bound_i | input | AW | Candidate upper bound (exclusive) |
| irq_pend_i | input | 1 | Interrupt pending, stop at next boundary |
| chk_addr_o | output | AW | Line base being checked for permission |
| chk_rd_ok_i | input | 1 | Read permitted at `chk_addr_o` |
| chk_wr_ok_i | input | 1 | Write permitted at `chk_addr_o` |
| req_valid_o | output | 1 | Line request valid |
| req_addr_o | output | AW | Line-aligned request address |
| req_op_o | output | 3 | Operation code for the request |
| rsp_ack_i | input | 1 | Line done |
| rsp_fault_i | input | 1 | Line faulted |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Result valid pulse |
| stop_o | output | AW | Returned stop address |
| exc_o | output | 3 | Exception code (0 none) |

## Verification
An acknowledge can meet three conditions in the same cycle: a pending interrupt, the line limit and the range end. A fault response can arrive while an interrupt is pending. The bench holds `irq_pend_i` high through a span whose first line faults and expects the fault to win: code 4 with the start address returned. It also drives a range that ends exactly on the MAX_LINES-th line and expects a plain completion. A behavioural model in the bench builds the expected line queue for each instruction, checks every handshake against it and compares the final stop address and exception code.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

   // operation codes seen on op_i / req_op_o
   typedef enum logic [2:0] {
      OP_CLEAN   = 3'd0,
      OP_FLUSH   = 3'd1,
      OP_ZALLOC  = 3'd2,
      OP_CLALLOC = 3'd3,
      OP_DISCARD = 3'd4,
      OP_HINT    = 3'd5
   } cmo_op_e;

   // exception codes returned on exc_o
   typedef enum logic [2:0] {
      EXC_NONE    = 3'd0,
      EXC_ILLEGAL = 3'd1,
      EXC_PRIV    = 3'd2,
      EXC_PERM    = 3'd3,
      EXC_CACHE   = 3'd4
   } exc_e;

   // kind of permission an operation needs per line
   typedef enum logic [1:0] {
      NEED_NONE  = 2'd0,
      NEED_READ  = 2'd1,
      NEED_WRITE = 2'd2,
      NEED_PRIV  = 2'd3
   } need_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_REQ   = 2'd2
   } walk_st_e;

endpackage

// File: rtl/rcs_range_calc.sv
module rcs_range_calc #(
   parameter int AW         = 32,
   parameter int LINE_BYTES = 64
) (
   input  logic [AW-1:0] lwb_i,
   input  logic [AW-1:0] bound_i,
   output logic [AW:0]   first_line_o,
   output logic [AW:0]   upb_o,
   output logic [AW-1:0] skip_stop_o
);

   localparam int LSB = $clog2(LINE_BYTES);
   localparam logic [AW:0] LINE_STEP = (AW+1)'(LINE_BYTES);

   logic [AW:0] lwb_ext;
   logic [AW:0] lwb_inc;
   logic [AW:0] bnd_ext;
   logic [AW:0] next_line;

   // arithmetic is one bit wider than the address so the top line has a
   // representable end and the upper bound never wraps to zero
   always_comb begin
      lwb_ext      = {1'b0, lwb_i};
      lwb_inc      = lwb_ext + (AW+1)'(1);
      bnd_ext      = {1'b0, bound_i};
      upb_o        = (bnd_ext > lwb_inc) ? bnd_ext : lwb_inc;
      first_line_o = {lwb_ext[AW:LSB], {LSB{1'b0}}};
      next_line    = first_line_o + LINE_STEP;
      skip_stop_o  = next_line[AW] ? {AW{1'b1}} : next_line[AW-1:0];
   end

endmodule

// File: rtl/rcs_access_policy.sv
module rcs_access_policy
   import rcs_pkg::*;
#(
   parameter int PRIV_W   = 2,
   parameter int PRIV_MIN = 3
) (
   input  logic [2:0]        op_i,
   input  logic [PRIV_W-1:0] priv_i,
   input  logic              skip_adv_i,
   input  logic              chk_rd_ok_i,
   input  logic              chk_wr_ok_i,
   output logic              op_bad_o,
   output logic              priv_fail_o,
   output logic              skip_o,
   output logic              line_ok_o
);

   need_e need;
   logic  advisory;

   always_comb begin
      need     = NEED_NONE;
      advisory = 1'b0;
      op_bad_o = 1'b0;
      case (op_i)
         OP_CLEAN,
         OP_FLUSH:   need = NEED_READ;
         OP_ZALLOC:  need = NEED_WRITE;
         OP_CLALLOC,
         OP_DISCARD: need = NEED_PRIV;
         OP_HINT: begin
            need     = NEED_READ;
            advisory = 1'b1;
         end
         default:    op_bad_o = 1'b1;
      endcase
   end

   always_comb begin
      priv_fail_o = (need == NEED_PRIV) && (priv_i < PRIV_W'(PRIV_MIN));
      skip_o      = advisory && skip_adv_i;
      case (need)
         NEED_READ:  line_ok_o = chk_rd_ok_i;
         NEED_WRITE: line_ok_o = chk_wr_ok_i;
         default:    line_ok_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/rcs_line_walker.sv
module rcs_line_walker
   import rcs_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LINE_BYTES = 64,
   parameter int MAX_LINES  = 16,
   parameter int REG_W      = 5,
   parameter bit IRQ_STOP   = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [REG_W-1:0] rd_idx_i,
   input  logic [REG_W-1:0] rs1_idx_i,
   input  logic [2:0]       op_i,
   input  logic [AW-1:0]    lwb_i,
   input  logic [AW:0]      first_line_i,
   input  logic [AW:0]      upb_i,
   input  logic [AW-1:0]    skip_stop_i,
   input  logic             op_bad_i,
   input  logic             priv_fail_i,
   input  logic             skip_i,
   input  logic             line_ok_i,
   input  logic             irq_i,
   input  logic             rsp_ack_i,
   input  logic             rsp_fault_i,
   output logic             busy_o,
   output logic [2:0]       op_q_o,
   output logic [AW-1:0]    cur_addr_o,
   output logic             req_valid_o,
   output logic             done_o,
   output logic [AW-1:0]    stop_o,
   output logic [2:0]       exc_o
);

   localparam int CNT_W = $clog2(MAX_LINES + 1);
   localparam logic [AW:0] LINE_STEP = (AW+1)'(LINE_BYTES);
   localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_LINES);

   walk_st_e         state_q;
   logic [AW:0]      cur_q;
   logic [AW:0]      upb_q;
   logic [AW-1:0]    lwb_q;
   logic [2:0]       op_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic [AW-1:0]    stop_q;
   exc_e             exc_q;

   logic [AW:0]      nxt_line;
   logic [AW-1:0]    nxt_stop;
   logic [AW-1:0]    fault_addr;
   logic [CNT_W-1:0] cnt_nxt;
   logic             range_end;
   logic             limit_hit;
   logic             irq_stop;
   logic             reg_clash;

   // interrupt-driven early exit is optional
   generate
      if (IRQ_STOP) begin : g_irq
         assign irq_stop = irq_i;
      end else begin : g_no_irq
         logic irq_unused;
         assign irq_unused = irq_i;
         assign irq_stop   = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt_line   = cur_q + LINE_STEP;
      nxt_stop   = nxt_line[AW] ? {AW{1'b1}} : nxt_line[AW-1:0];
      fault_addr = (cur_q < {1'b0, lwb_q}) ? lwb_q : cur_q[AW-1:0];
      cnt_nxt    = cnt_q + CNT_W'(1);
      range_end  = (nxt_line >= upb_q);
      limit_hit  = (cnt_nxt == CNT_LIMIT);
      reg_clash  = (rd_idx_i != rs1_idx_i);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cur_q   <= '0;
         upb_q   <= '0;
         lwb_q   <= '0;
         op_q    <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         stop_q  <= '0;
         exc_q   <= EXC_NONE;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  lwb_q <= lwb_i;
                  op_q  <= op_i;
                  upb_q <= upb_i;
                  cur_q <= first_line_i;
                  cnt_q <= '0;
                  if (reg_clash || op_bad_i) begin
                     done_q <= 1'b1;
                     exc_q  <= EXC_ILLEGAL;
                     stop_q <= lwb_i;
                  end else if (priv_fail_i) begin
                     done_q <= 1'b1;
                     exc_q  <= EXC_PRIV;
                     stop_q <= lwb_i;
                  end else if (skip_i) begin
                     done_q <= 1'b1;
                     exc_q  <= EXC_NONE;
                     stop_q <= skip_stop_i;
                  end else begin
                     state_q <= ST_CHECK;
                  end
               end
            end
            ST_CHECK: begin
               if (line_ok_i) begin
                  state_q <= ST_REQ;
               end else begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  exc_q   <= EXC_PERM;
                  stop_q  <= fault_addr;
               end
            end
            ST_REQ: begin
               if (rsp_fault_i) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  exc_q   <= EXC_CACHE;
                  stop_q  <= fault_addr;
               end else if (rsp_ack_i) begin
                  cnt_q <= cnt_nxt;
                  if (range_end || limit_hit || irq_stop) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     exc_q   <= EXC_NONE;
                     stop_q  <= nxt_stop;
                  end else begin
                     cur_q   <= nxt_line;
                     state_q <= ST_CHECK;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign op_q_o      = op_q;
   assign cur_addr_o  = cur_q[AW-1:0];
   assign req_valid_o = (state_q == ST_REQ);
   assign done_o      = done_q;
   assign stop_o      = stop_q;
   assign exc_o       = exc_q;

endmodule

// File: rtl/range_cmo_seq.sv
module range_cmo_seq #(
   parameter int AW         = 32,
   parameter int LINE_BYTES = 64,
   parameter int MAX_LINES  = 16,
   parameter int REG_W      = 5,
   parameter int PRIV_W     = 2,
   parameter int PRIV_MIN   = 3,
   parameter bit IRQ_STOP   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [REG_W-1:0]  rd_idx_i,
   input  logic [REG_W-1:0]  rs1_idx_i,
   input  logic [2:0]        op_i,
   input  logic [PRIV_W-1:0] priv_i,
   input  logic              skip_adv_i,
   input  logic [AW-1:0]     lwb_i,
   input  logic [AW-1:0]     bound_i,
   input  logic              irq_pend_i,
   output logic [AW-1:0]     chk_addr_o,
   input  logic              chk_rd_ok_i,
   input  logic              chk_wr_ok_i,
   output logic              req_valid_o,
   output logic [AW-1:0]     req_addr_o,
   output logic [2:0]        req_op_o,
   input  logic              rsp_ack_i,
   input  logic              rsp_fault_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [AW-1:0]     stop_o,
   output logic [2:0]        exc_o
);

   localparam int LSB = $clog2(LINE_BYTES);

   // elaboration-time parameter checks
   generate
      if ((1 << LSB) != LINE_BYTES || LINE_BYTES < 2) begin : g_bad_line
         $error("LINE_BYTES must be a power of two of at least 2");
      end
      if (LSB >= AW) begin : g_bad_aw
         $error("AW must exceed log2(LINE_BYTES)");
      end
      if (MAX_LINES < 1) begin : g_bad_max
         $error("MAX_LINES must be at least 1");
      end
      if (PRIV_MIN >= (1 << PRIV_W)) begin : g_bad_priv
         $error("PRIV_MIN must fit in PRIV_W bits");
      end
   endgenerate

   logic [AW:0]     first_line;
   logic [AW:0]     upb_ext;
   logic [AW-1:0]   skip_stop;
   logic [2:0]      op_q;
   logic [2:0]      pol_op;
   logic            op_bad;
   logic            priv_fail;
   logic            skip_adv;
   logic            line_ok;
   logic [AW-1:0]   cur_addr;

   // while a walk runs, the policy judges the captured operation
   assign pol_op = busy_o ? op_q : op_i;

   rcs_range_calc #(
      .AW         (AW),
      .LINE_BYTES (LINE_BYTES)
   ) i_range (
      .lwb_i        (lwb_i),
      .bound_i      (bound_i),
      .first_line_o (first_line),
      .upb_o        (upb_ext),
      .skip_stop_o  (skip_stop)
   );

   rcs_access_policy #(
      .PRIV_W   (PRIV_W),
      .PRIV_MIN (PRIV_MIN)
   ) i_policy (
      .op_i        (pol_op),
      .priv_i      (priv_i),
      .skip_adv_i  (skip_adv_i),
      .chk_rd_ok_i (chk_rd_ok_i),
      .chk_wr_ok_i (chk_wr_ok_i),
      .op_bad_o    (op_bad),
      .priv_fail_o (priv_fail),
      .skip_o      (skip_adv),
      .line_ok_o   (line_ok)
   );

   rcs_line_walker #(
      .AW         (AW),
      .LINE_BYTES (LINE_BYTES),
      .MAX_LINES  (MAX_LINES),
      .REG_W      (REG_W),
      .IRQ_STOP   (IRQ_STOP)
   ) i_walker (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .start_i      (start_i),
      .rd_idx_i     (rd_idx_i),
      .rs1_idx_i    (rs1_idx_i),
      .op_i         (op_i),
      .lwb_i        (lwb_i),
      .first_line_i (first_line),
      .upb_i        (upb_ext),
      .skip_stop_i  (skip_stop),
      .op_bad_i     (op_bad),
      .priv_fail_i  (priv_fail),
      .skip_i       (skip_adv),
      .line_ok_i    (line_ok),
      .irq_i        (irq_pend_i),
      .rsp_ack_i    (rsp_ack_i),
      .rsp_fault_i  (rsp_fault_i),
      .busy_o       (busy_o),
      .op_q_o       (op_q),
      .cur_addr_o   (cur_addr),
      .req_valid_o  (req_valid_o),
      .done_o       (done_o),
      .stop_o       (stop_o),
      .exc_o        (exc_o)
   );

   assign chk_addr_o = cur_addr;
   assign req_addr_o = cur_addr;
   assign req_op_o   = op_q;

endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
   parameter int AW         = 32,
   parameter int LINE_BYTES = 64,
   parameter int REG_W      = 5
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             start_i,
   input logic [REG_W-1:0] rd_idx_i,
   input logic [REG_W-1:0] rs1_idx_i,
   input logic [AW-1:0]    lwb_i,
   input logic [AW-1:0]    bound_i,
   input logic             req_valid_o,
   input logic [AW-1:0]    req_addr_o,
   input logic             rsp_ack_i,
   input logic             rsp_fault_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [AW-1:0]    stop_o,
   input logic [2:0]       exc_o
);

   localparam int LSB = $clog2(LINE_BYTES);

   logic [AW-1:0] lwb_t;
   logic [AW:0]   upb_t;
   logic          accept;

   assign accept = start_i && !busy_o;

   // bound captured from the ports at acceptance, from the range rule
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lwb_t <= '0;
         upb_t <= '0;
      end else if (accept) begin
         lwb_t <= lwb_i;
         if ({1'b0, bound_i} > ({1'b0, lwb_i} + (AW+1)'(1)))
            upb_t <= {1'b0, bound_i};
         else
            upb_t <= {1'b0, lwb_i} + (AW+1)'(1);
      end
   end

   // R1
   illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept && (rd_idx_i != rs1_idx_i) |=> done_o && (exc_o == 3'd1));

   // R3
   req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_o && !rsp_ack_i && !rsp_fault_i |=> req_valid_o && $stable(req_addr_o));

   // R3
   req_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_o |-> (req_addr_o[LSB-1:0] == '0));

   // R4
   req_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_o |-> ({1'b0, req_addr_o} < upb_t));

   // R5
   progress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && (exc_o == 3'd0) |-> (stop_o > lwb_t) || (&stop_o));

   // R6
   fault_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && (exc_o == 3'd4) |-> (stop_o >= lwb_t));

   // R12
   req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_o |-> busy_o);

   // R12
   done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

endmodule

bind range_cmo_seq rcs_checker #(
   .AW         (AW),
   .LINE_BYTES (LINE_BYTES),
   .REG_W      (REG_W)
) i_rcs_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .start_i     (start_i),
   .rd_idx_i    (rd_idx_i),
   .rs1_idx_i   (rs1_idx_i),
   .lwb_i       (lwb_i),
   .bound_i     (bound_i),
   .req_valid_o (req_valid_o),
   .req_addr_o  (req_addr_o),
   .rsp_ack_i   (rsp_ack_i),
   .rsp_fault_i (rsp_fault_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .stop_o      (stop_o),
   .exc_o       (exc_o)
);

// File: tb/test_range_cmo_seq.sv
module test_range_cmo_seq;

   localparam int AW   = 32;
   localparam int LB   = 64;
   localparam int MAXL = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [4:0]    rd_idx = '0;
   logic [4:0]    rs1_idx = '0;
   logic [2:0]    op = '0;
   logic [1:0]    priv = '0;
   logic          skip_adv = 1'b0;
   logic [AW-1:0] lwb = '0;
   logic [AW-1:0] bound = '0;
   logic          irq = 1'b0;
   logic [AW-1:0] chk_addr;
   logic          chk_rd_ok;
   logic          chk_wr_ok;
   logic          req_valid;
   logic [AW-1:0] req_addr;
   logic [2:0]    req_op;
   logic          rsp_ack = 1'b0;
   logic          rsp_fault = 1'b0;
   logic          busy;
   logic          done;
   logic [AW-1:0] stop;
   logic [2:0]    exc;

   always #5 clk = ~clk;

   range_cmo_seq #(
      .AW(AW), .LINE_BYTES(LB), .MAX_LINES(MAXL), .REG_W(5),
      .PRIV_W(2), .PRIV_MIN(3), .IRQ_STOP(1'b1)
   ) i_range_cmo_seq (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_idx_i(rd_idx),
      .rs1_idx_i(rs1_idx), .op_i(op), .priv_i(priv), .skip_adv_i(skip_adv),
      .lwb_i(lwb), .bound_i(bound), .irq_pend_i(irq), .chk_addr_o(chk_addr),
      .chk_rd_ok_i(chk_rd_ok), .chk_wr_ok_i(chk_wr_ok), .req_valid_o(req_valid),
      .req_addr_o(req_addr), .req_op_o(req_op), .rsp_ack_i(rsp_ack),
      .rsp_fault_i(rsp_fault), .busy_o(busy), .done_o(done), .stop_o(stop),
      .exc_o(exc)
   );

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   // environment knobs
   logic [63:0] rd_deny    = 64'h1_0000_0000;
   bit          wr_allow   = 1'b1;
   logic [63:0] fault_line = '1;
   int          ack_delay  = 0;

   // model outputs
   logic [63:0] exp_q[$];
   logic [31:0] exp_stop;
   logic [2:0]  exp_exc;
   bit          exp_now;
   logic [2:0]  cur_op;
   int          wait_cnt = 0;

   assign chk_rd_ok = ({32'b0, chk_addr} < rd_deny);
   assign chk_wr_ok = wr_allow;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, expv, $time);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   function automatic logic [31:0] sat(input logic [63:0] v);
      return (v > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : v[31:0];
   endfunction

   // behavioural reference: expected line list, stop address and code
   task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [2:0] o,
                        input logic [1:0] p, input bit same, input bit skip, input bit irqv);
      logic [63:0] upb, cur, nxt;
      int n;
      bit ok;
      exp_q.delete();
      exp_now = 1'b1;
      if (!same || o > 3'd5) begin
         exp_exc = 3'd1; exp_stop = a; return;
      end
      if ((o == 3'd3 || o == 3'd4) && p < 2'd3) begin
         exp_exc = 3'd2; exp_stop = a; return;
      end
      if (o == 3'd5 && skip) begin
         exp_exc = 3'd0; exp_stop = sat(((64'(a) / LB) + 1) * LB); return;
      end
      exp_now = 1'b0;
      upb = (64'(b) > 64'(a) + 1) ? 64'(b) : 64'(a) + 1;
      cur = (64'(a) / LB) * LB;
      n = 0;
      while (1) begin
         if (o == 3'd2) ok = wr_allow;
         else if (o == 3'd3 || o == 3'd4) ok = 1'b1;
         else ok = (cur < rd_deny);
         if (!ok) begin
            exp_exc = 3'd3; exp_stop = (cur < 64'(a)) ? a : cur[31:0]; return;
         end
         exp_q.push_back(cur);
         if (cur == fault_line) begin
            exp_exc = 3'd4; exp_stop = (cur < 64'(a)) ? a : cur[31:0]; return;
         end
         nxt = cur + LB;
         n++;
         if (nxt >= upb || n == MAXL || irqv) begin
            exp_exc = 3'd0; exp_stop = sat(nxt); return;
         end
         cur = nxt;
      end
   endtask

   // cache responder and per-clock comparison against the model queue
   always @(negedge clk) begin
      rsp_ack   = 1'b0;
      rsp_fault = 1'b0;
      if (rst_n) begin
         if (req_valid && !busy)
            check(1'b0, "R12 req while idle", 64'(busy), 64'd1);
         if (req_valid) begin
            if (wait_cnt < ack_delay) begin
               wait_cnt++;
            end else begin
               wait_cnt = 0;
               if (exp_q.size() == 0) begin
                  check(1'b0, "R4 unexpected request", 64'(req_addr), 64'd0);
               end else begin
                  check(req_addr == exp_q[0][31:0], "R3 request address",
                        64'(req_addr), exp_q[0]);
                  check(req_op == cur_op, "R3 request op", 64'(req_op), 64'(cur_op));
                  void'(exp_q.pop_front());
               end
               if (64'(req_addr) == fault_line) rsp_fault = 1'b1;
               else rsp_ack = 1'b1;
            end
         end else begin
            wait_cnt = 0;
         end
      end
   end

   task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                      input logic [2:0] o, input logic [1:0] p, input bit same,
                      input bit skip, input bit irqv, input bit poke);
      int guard;
      model(a, b, o, p, same, skip, irqv);
      cur_op = o;
      @(negedge clk);
      lwb = a; bound = b; op = o; priv = p; skip_adv = skip; irq = irqv;
      rs1_idx = 5'd11; rd_idx = same ? 5'd11 : 5'd12;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (!exp_now)
         check(busy && !done, {req, " busy after accept"}, 64'(busy), 64'd1);
      if (poke && busy) begin
         // a second start while busy, with mismatched registers, must be ignored
         rd_idx = 5'd3; op = 3'd7; lwb = 32'h0; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (!done && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      check(done == 1'b1, {req, " done seen"}, 64'(done), 64'd1);
      check(!busy, "R12 idle with done", 64'(busy), 64'd0);
      check(stop == exp_stop, {req, " stop address"}, 64'(stop), 64'(exp_stop));
      check(exc == exp_exc, {req, " exception code"}, 64'(exc), 64'(exp_exc));
      check(exp_q.size() == 0, {req, " all lines requested"}, 64'(exp_q.size()), 64'd0);
      @(negedge clk);
      check(!done, "R12 done is one pulse", 64'(done), 64'd0);
      irq = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R12 watchdog expired act=%0d exp=%0d", 200000, 0);
      summary();
   end

   initial begin
      logic [31:0] a;
      int iter;
      repeat (3) @(negedge clk);
      // R12 reset state
      check(!busy && !done && !req_valid, "R12 reset outputs", 64'({busy, done, req_valid}), 64'd0);
      check(stop == '0 && exc == '0, "R12 reset result", 64'({stop, exc}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R5 aligned clean
      run("R5 aligned clean", 32'h1000, 32'h1100, 3'd0, 2'd0, 1, 0, 0, 0);
      // R3 R4 unaligned bounds, last line reaches past bound
      run("R4 unaligned flush", 32'h2010, 32'h20C1, 3'd1, 2'd0, 1, 0, 0, 0);
      // R4 bound exactly on a line base: that line is excluded
      run("R4 bound on boundary", 32'h2010, 32'h20C0, 3'd1, 2'd0, 1, 0, 0, 0);
      // R2 start above the candidate bound still does one line
      run("R2 empty range", 32'h3030, 32'h0000_0100, 3'd0, 2'd0, 1, 0, 0, 0);
      // R1 register mismatch
      run("R1 reg mismatch", 32'h3100, 32'h3200, 3'd0, 2'd0, 0, 0, 0, 0);
      // R13 illegal operation codes
      run("R13 op 6", 32'h3140, 32'h3200, 3'd6, 2'd3, 1, 0, 0, 0);
      run("R13 op 7", 32'h3140, 32'h3200, 3'd7, 2'd3, 1, 0, 0, 0);
      // R8 privilege
      run("R8 discard low priv", 32'h3300, 32'h3400, 3'd4, 2'd1, 1, 0, 0, 0);
      rd_deny = 64'h0; wr_allow = 1'b0;
      run("R8 clalloc high priv no addr check", 32'h3300, 32'h3380, 3'd3, 2'd3, 1, 0, 0, 0);
      // R11 advisory skip ignores permissions
      run("R11 hint skipped", 32'hA010, 32'hA400, 3'd5, 2'd0, 1, 1, 0, 0);
      rd_deny = 64'h1_0000_0000; wr_allow = 1'b1;
      run("R11 hint performed", 32'hA010, 32'hA0C0, 3'd5, 2'd0, 1, 0, 0, 0);
      // R7 read denial mid range, write denial on first line
      rd_deny = 64'h4080;
      run("R7 flush read denied", 32'h4000, 32'h4200, 3'd1, 2'd0, 1, 0, 0, 0);
      rd_deny = 64'h1_0000_0000; wr_allow = 1'b0;
      run("R7 zalloc write denied", 32'h5010, 32'h5100, 3'd2, 2'd0, 1, 0, 0, 0);
      wr_allow = 1'b1;
      run("R7 zalloc allowed", 32'h5010, 32'h5100, 3'd2, 2'd0, 1, 0, 0, 0);
      // R6 cache faults
      fault_line = 64'h6080;
      run("R6 fault mid range", 32'h6010, 32'h6200, 3'd0, 2'd0, 1, 0, 0, 0);
      fault_line = 64'h7000;
      run("R6 fault first line", 32'h7020, 32'h7200, 3'd1, 2'd0, 1, 0, 0, 0);
      // R10 R6 interrupt pending while the first line faults: fault wins
      run("R6 fault with irq", 32'h7020, 32'h7200, 3'd1, 2'd0, 1, 0, 1, 0);
      fault_line = '1;
      // R10 interrupt stops after one line
      run("R10 irq stop", 32'h9000, 32'h9200, 3'd0, 2'd0, 1, 0, 1, 0);
      // R9 limit and software restart loop (20 lines, two issues)
      a = 32'h8000;
      iter = 0;
      do begin
         run("R9 limited issue", a, 32'h8500, 3'd1, 2'd0, 1, 0, 0, 0);
         a = stop;
         iter++;
      end while (a < 32'h8500 && iter < 5);
      check(iter == 2, "R9 issue count", 64'(iter), 64'd2);
      check(a == 32'h8500, "R9 final stop", 64'(a), 64'h8500);
      // R9 R5 range ends on exactly the last permitted line
      run("R9 limit meets end", 32'hB000, 32'hB400, 3'd0, 2'd0, 1, 0, 0, 0);
      // R5 top of address space saturates
      run("R5 saturate at top", 32'hFFFF_FFF0, 32'h0, 3'd0, 2'd0, 1, 0, 0, 0);
      // R3 held request under slow acknowledge, R12 start while busy ignored
      ack_delay = 3;
      run("R3 slow ack", 32'hC000, 32'hC100, 3'd1, 2'd0, 1, 0, 0, 1);
      ack_delay = 0;
      summary();
   end

endmodule